// File: doc/BRIEF.md
# Distributed Shared-Bus Arbitration Node

Each processor on a shared parallel bus carries one copy of this unit. The bus has room for up to six processors. A node is told its own ID, in the range 1 to 6. It drives a single request line of its own and reads all six request lines, which are wired together outside the block. There is no central arbiter. Every node sees the same request lines and holds the same state, so every node reaches the same decision about which ID owns the bus.

A node owns the bus for as long as its request line stays high. Ownership moves only in a transition cycle: the current owner has dropped its line and at least one other line is high. A mode input selects the priority scheme, either fixed or rotating. On top of plain arbitration the node supports three things:
- a lock, for indivisible read-modify-write sequences;
- an optional limit on how long one owner may keep the bus;
- a core-priority request, which makes an owner that only moves bulk data give way to a processor core.

Top module: `node_bus_arbiter`

## Requirements
- R1: `br_o` is a register. One cycle after `dma_req_i | core_req_i` is applied, it shows that value, unless R8, R9 or R10 overrides it. On the bus, node ID k drives bit k-1 of the six-bit request vector.
- R2: During reset `br_o` is 0 and `master_o` is 0, meaning no owner. From this idle state, the cycle after any request bit is seen, `master_o` takes the ID of the highest-priority requester.
- R3: When the owner's request bit is 0 and some other bit is 1 (a transition cycle), `master_o` takes the winning ID on the next cycle. That winning ID is never the previous owner.
- R4: While the owner's request bit stays 1, `master_o` does not change, whatever the other bits do.
- R5: If the owner drops its bit and no other bit is 1, `master_o` keeps the old ID. If that node raises its bit again, it has the bus back with no transition.
- R6: With `rotate_i`=0 (fixed priority), the lowest requesting ID wins.
- R7: With `rotate_i`=1 (rotating priority), the search for a winner starts at a pointer ID and wraps from 6 to 1. The pointer is 1 after reset. On each grant made in rotating mode, the pointer moves to the ID after the new owner, with 6 followed by 1.
- R8: While a node owns the bus and `lock_i` is 1, its `br_o` is 1 on the next cycle, even if R9 or R10 would drop it.
- R9: A hold count is cleared on every grant. It then adds one, saturating, on each cycle the owner's bit is 1. Suppose `limit_en_i` is 1, the count is at least `limit_i`, and another bit is 1. Then the owning node's `br_o` is 0 on the next cycle.
- R10: `cpa_o` follows `core_req_i` with no delay. Suppose an owner with `core_req_i`=0 and `lock_i`=0 sees a `cpa_i` bit set for some other node. Then it drives `br_o`=0 on the next cycle.
- R11: All nodes on one bus report the same `master_o` on every cycle. `grant_o` is 1 only in the node whose ID equals `master_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| node_id_i | input | 3 | This node's ID, 1 to 6 |
| rotate_i | input | 1 | 1 selects rotating priority, 0 selects fixed priority |
| dma_req_i | input | 1 | Bulk-transfer request for the bus |
| core_req_i | input | 1 | Core request for the bus, which also has priority access |
| lock_i | input | 1 | Keep the bus while owned |
| limit_en_i | input | 1 | Turns on the hold limit |
| limit_i | input | 8 | Hold limit, in cycles |
| br_i | input | 6 | Request lines of all nodes, bit k-1 for ID k |
| cpa_i | input | 6 | Priority-access lines of all nodes |
| br_o | output | 1 | This node's request line |
| cpa_o | output | 1 | This node's priority-access line |
| master_o | output | 3 | Current owner ID, 0 when there is none |
| grant_o | output | 1 | This node owns the bus |

## Verification
The hardest state to reach from outside is an owner running into the hold limit, or a priority-access yield, while other nodes are also requesting. The forced release has to be followed by a handover that all six copies agree on. The bench therefore builds a full six-node bus and checks it each cycle against a system model kept in the bench. Directed phases fix a small limit with two contenders, lock one owner, and raise a core request against an owner doing bulk transfers. Seeded random phases in both priority modes then toggle requests, locks and core flags to mix these effects together.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic {
    PRIO_FIXED  = 1'b0,
    PRIO_ROTATE = 1'b1
  } prio_mode_e;

  typedef enum logic [1:0] {
    REQ_FOLLOW = 2'd0,
    REQ_LOCKED = 2'd1,
    REQ_LIMIT  = 2'd2,
    REQ_YIELD  = 2'd3
  } req_cause_e;
endpackage

// File: rtl/arb_prio_pick.sv
module arb_prio_pick #(
  parameter int N  = 6,
  parameter int IW = 3
) (
  input  logic [N-1:0]  req_i,
  input  arb_pkg::prio_mode_e mode_i,
  input  logic [IW-1:0] top_i,
  output logic [IW-1:0] win_o,
  output logic          any_o
);
  logic [N-1:0] found;
  logic [IW-1:0] cand [N];

  // candidate order: fixed = 1..N, rotating = top..N,1..top-1
  for (genvar i = 0; i < N; i++) begin : g_cand
    always_comb begin
      if (mode_i == arb_pkg::PRIO_ROTATE)
        cand[i] = IW'(((int'(top_i) - 1 + i) % N) + 1);
      else
        cand[i] = IW'(i + 1);
    end
  end

  always_comb begin
    win_o = '0;
    found = '0;
    for (int i = 0; i < N; i++) begin
      found[i] = req_i[int'(cand[i]) - 1];
      if (found[i] && win_o == '0) win_o = cand[i];
    end
    any_o = |req_i;
  end
endmodule

// File: rtl/arb_hold_cnt.sv
module arb_hold_cnt #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          inc_i,
  output logic [CW-1:0] cnt_o
);
  localparam logic [CW-1:0] CMax = {CW{1'b1}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_o <= '0;
    else if (clear_i)               cnt_o <= '0;
    else if (inc_i && cnt_o != CMax) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/node_bus_arbiter.sv
module node_bus_arbiter #(
  parameter int N  = 6,
  parameter int IW = 3,
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [IW-1:0] node_id_i,
  input  logic          rotate_i,
  input  logic          dma_req_i,
  input  logic          core_req_i,
  input  logic          lock_i,
  input  logic          limit_en_i,
  input  logic [CW-1:0] limit_i,
  input  logic [N-1:0]  br_i,
  input  logic [N-1:0]  cpa_i,
  output logic          br_o,
  output logic          cpa_o,
  output logic [IW-1:0] master_o,
  output logic          grant_o
);
  import arb_pkg::*;

  localparam logic [IW-1:0] LastId = IW'(N);

  logic [IW-1:0] master_q, master_d, top_q, top_d, win;
  logic [N-1:0]  own_vec, mst_vec;
  logic          any_req, mst_req, new_grant, own_master;
  logic          others_req, others_cpa, limit_hit;
  logic [CW-1:0] hold_cnt;
  prio_mode_e    mode;
  req_cause_e    cause;
  logic          br_q, br_d;

  assign mode = prio_mode_e'(rotate_i);

  for (genvar i = 0; i < N; i++) begin : g_dec
    assign own_vec[i] = (node_id_i == IW'(i + 1));
    assign mst_vec[i] = (master_q  == IW'(i + 1));
  end

  arb_prio_pick #(.N(N), .IW(IW)) i_pick (
    .req_i (br_i),
    .mode_i(mode),
    .top_i (top_q),
    .win_o (win),
    .any_o (any_req)
  );

  assign mst_req   = |(mst_vec & br_i);
  // idle grant or transition cycle
  assign new_grant = any_req && !mst_req;
  assign master_d  = new_grant ? win : master_q;

  always_comb begin
    top_d = top_q;
    if (new_grant && mode == PRIO_ROTATE)
      top_d = (win == LastId) ? IW'(1) : win + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      master_q <= '0;
      top_q    <= IW'(1);
    end else begin
      master_q <= master_d;
      top_q    <= top_d;
    end
  end

  arb_hold_cnt #(.CW(CW)) i_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(new_grant),
    .inc_i  (mst_req),
    .cnt_o  (hold_cnt)
  );

  assign own_master = (master_q != '0) && (master_q == node_id_i);
  assign others_req = |(br_i & ~own_vec);
  assign others_cpa = |(cpa_i & ~own_vec);
  assign limit_hit  = limit_en_i && (hold_cnt >= limit_i);

  always_comb begin
    cause = REQ_FOLLOW;
    if (own_master && lock_i)                          cause = REQ_LOCKED;
    else if (own_master && limit_hit && others_req)    cause = REQ_LIMIT;
    else if (own_master && others_cpa && !core_req_i)  cause = REQ_YIELD;
    unique case (cause)
      REQ_LOCKED:           br_d = 1'b1;
      REQ_LIMIT, REQ_YIELD: br_d = 1'b0;
      default:              br_d = dma_req_i | core_req_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) br_q <= 1'b0;
    else         br_q <= br_d;
  end

  assign br_o     = br_q;
  assign cpa_o    = core_req_i;
  assign master_o = master_q;
  assign grant_o  = own_master;
endmodule

// File: rtl/node_bus_arbiter_chk.sv
module node_bus_arbiter_chk #(
  parameter int N  = 6,
  parameter int IW = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [IW-1:0] node_id_i,
  input logic          rotate_i,
  input logic          core_req_i,
  input logic          lock_i,
  input logic [N-1:0]  br_i,
  input logic [N-1:0]  cpa_i,
  input logic          br_o,
  input logic [IW-1:0] master_o,
  input logic          grant_o
);
  function automatic logic bit_of(logic [N-1:0] v, logic [IW-1:0] id);
    logic r;
    r = 1'b0;
    for (int i = 0; i < N; i++) if (id == IW'(i + 1)) r = v[i];
    return r;
  endfunction

  function automatic logic [IW-1:0] lowest(logic [N-1:0] v);
    logic [IW-1:0] r;
    r = '0;
    for (int i = N - 1; i >= 0; i--) if (v[i]) r = IW'(i + 1);
    return r;
  endfunction

  function automatic logic others_set(logic [N-1:0] v, logic [IW-1:0] id);
    logic r;
    r = 1'b0;
    for (int i = 0; i < N; i++) if (v[i] && id != IW'(i + 1)) r = 1'b1;
    return r;
  endfunction

  logic trans_now;
  assign trans_now = !bit_of(br_i, master_o) && (br_i != '0);

  p_keep_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_of(br_i, master_o) |=> master_o == $past(master_o));

  p_park_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    br_i == '0 |=> master_o == $past(master_o));

  p_handover_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_o != '0 && trans_now) |=> master_o != $past(master_o));

  p_fixed_lowest_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rotate_i && trans_now) |=> master_o == lowest($past(br_i)));

  p_lock_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o && lock_i) |=> br_o);

  p_yield_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o && !lock_i && !core_req_i && others_set(cpa_i, node_id_i)) |=> !br_o);

  p_grant_id_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |-> (master_o == node_id_i && master_o != '0));
endmodule

bind node_bus_arbiter node_bus_arbiter_chk #(.N(N), .IW(IW)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .node_id_i (node_id_i),
  .rotate_i  (rotate_i),
  .core_req_i(core_req_i),
  .lock_i    (lock_i),
  .br_i      (br_i),
  .cpa_i     (cpa_i),
  .br_o      (br_o),
  .master_o  (master_o),
  .grant_o   (grant_o)
);

// File: tb/test_node_bus_arbiter.sv
module test_node_bus_arbiter;
  localparam int N  = 6;
  localparam int IW = 3;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk = ~clk;

  logic rotate = 1'b0, limit_en = 1'b0;
  logic [CW-1:0] limit = '0;
  logic [N-1:0] dma = '0, core = '0, lock = '0;
  wire  [N-1:0] br_bus, cpa_bus;
  wire  [IW-1:0] mst [N];
  wire  [N-1:0] gnt;

  for (genvar g = 0; g < N; g++) begin : g_node
    node_bus_arbiter #(.N(N), .IW(IW), .CW(CW)) i_node_bus_arbiter (
      .clk_i     (clk),
      .rst_ni    (rst_ni),
      .node_id_i (IW'(g + 1)),
      .rotate_i  (rotate),
      .dma_req_i (dma[g]),
      .core_req_i(core[g]),
      .lock_i    (lock[g]),
      .limit_en_i(limit_en),
      .limit_i   (limit),
      .br_i      (br_bus),
      .cpa_i     (cpa_bus),
      .br_o      (br_bus[g]),
      .cpa_o     (cpa_bus[g]),
      .master_o  (mst[g]),
      .grant_o   (gnt[g])
    );
  end

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 1'b0;
  always @(posedge clk) cyc++;

  logic [IW-1:0] m_master = '0, m_top = IW'(1);
  logic [CW-1:0] m_cnt = '0;
  logic [N-1:0]  m_br = '0;

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  function automatic logic [IW-1:0] pick(logic [N-1:0] r, logic rot, logic [IW-1:0] top);
    logic [IW-1:0] w;
    w = '0;
    for (int i = 0; i < N; i++) begin
      int idx;
      idx = rot ? ((int'(top) - 1 + i) % N) : i;
      if (w == '0 && r[idx]) w = IW'(idx + 1);
    end
    return w;
  endfunction

  task automatic compare(string tag);
    bit agree;
    chk(br_bus === m_br, {tag, " bus"}, int'(br_bus), int'(m_br));
    agree = 1'b1;
    for (int n = 0; n < N; n++) begin
      if (mst[n] !== m_master) agree = 1'b0;
      if (gnt[n] !== (m_master == IW'(n + 1))) agree = 1'b0;
    end
    chk(agree, {tag, " master/R11"}, int'(mst[0]), int'(m_master));
  endtask

  // model one edge from current inputs, then compare after it
  task automatic step(string tag);
    logic [N-1:0] nbr;
    logic [IW-1:0] win, n_master, n_top;
    logic [CW-1:0] n_cnt;
    bit mreq, newg, lim;
    mreq = (m_master != '0) && m_br[int'(m_master) - 1];
    newg = (m_br != '0) && !mreq;
    win  = pick(m_br, rotate, m_top);
    lim  = limit_en && (m_cnt >= limit);
    for (int n = 0; n < N; n++) begin
      bit own, oth, ocpa;
      own  = (m_master == IW'(n + 1));
      oth  = |(m_br & ~(N'(1) << n));
      ocpa = |(core & ~(N'(1) << n));
      if (own && lock[n])              nbr[n] = 1'b1;
      else if (own && lim && oth)      nbr[n] = 1'b0;
      else if (own && ocpa && !core[n]) nbr[n] = 1'b0;
      else                             nbr[n] = dma[n] | core[n];
    end
    n_master = newg ? win : m_master;
    n_top    = (newg && rotate) ? ((win == IW'(N)) ? IW'(1) : win + 1'b1) : m_top;
    n_cnt    = newg ? '0 : (mreq && m_cnt != {CW{1'b1}}) ? m_cnt + 1'b1 : m_cnt;
    @(posedge clk);
    @(negedge clk);
    m_br = nbr; m_master = n_master; m_top = n_top; m_cnt = n_cnt;
    compare(tag);
  endtask

  task automatic idle(int k, string tag);
    dma = '0; core = '0; lock = '0;
    repeat (k) step(tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int changes;
    logic [IW-1:0] prev;
    void'($urandom(32'd5171));
    #5;
    // R2: reset state
    chk(br_bus == '0, "R2 reset bus", int'(br_bus), 0);
    chk(mst[0] == '0 && mst[5] == '0 && gnt == '0, "R2 reset master", int'(mst[0]), 0);
    @(negedge clk); @(negedge clk);
    rst_ni = 1'b1;

    // R2/R1: first requesters from idle, fixed priority
    dma[2] = 1'b1; dma[4] = 1'b1;
    step("R1");
    chk(br_bus == 6'b010100, "R1 own line", int'(br_bus), 20);
    chk(mst[0] == '0, "R2 no owner yet", int'(mst[0]), 0);
    step("R2");
    chk(mst[0] == 3'd3, "R2 first owner", int'(mst[0]), 3);

    // R4: owner holds while 5 waits
    repeat (5) step("R4");
    chk(mst[2] == 3'd3, "R4 keep", int'(mst[2]), 3);

    // R6: 3 drops, 2 and 5 contend -> 2 wins under fixed
    dma[2] = 1'b0; dma[1] = 1'b1;
    step("R3"); step("R6");
    chk(mst[4] == 3'd2, "R6 lowest wins", int'(mst[4]), 2);

    // R5: everyone drops, owner parks, re-raise resumes
    dma = '0;
    repeat (3) step("R5");
    chk(mst[0] == 3'd2, "R5 parked", int'(mst[0]), 2);
    dma[1] = 1'b1;
    repeat (3) step("R5");
    chk(mst[3] == 3'd2 && gnt[1], "R5 resume", int'(mst[3]), 2);
    idle(2, "R5");

    // R7: rotating, every non-owner requests, owner drops
    rotate = 1'b1;
    for (int k = 0; k < 30; k++) begin
      for (int n = 0; n < N; n++) dma[n] = (m_master != IW'(n + 1));
      step("R7");
    end
    idle(3, "R7");

    // R9: hold limit between two contenders
    rotate = 1'b0; limit_en = 1'b1; limit = 8'd3;
    dma[0] = 1'b1; dma[3] = 1'b1;
    changes = 0; prev = mst[0];
    for (int k = 0; k < 30; k++) begin
      step("R9");
      if (mst[0] != prev) changes++;
      prev = mst[0];
    end
    chk(changes >= 2, "R9 forced handovers", changes, 2);

    // R8: lock keeps node 1 despite limit
    lock[0] = 1'b1;
    for (int k = 0; k < 20 && mst[0] != 3'd1; k++) step("R8");
    changes = 0;
    for (int k = 0; k < 12; k++) begin
      step("R8");
      if (mst[0] != 3'd1) changes++;
    end
    chk(changes == 0, "R8 locked owner", changes, 0);
    lock = '0; limit_en = 1'b0;
    idle(3, "R8");

    // R10: core priority access makes bulk owner yield
    dma[0] = 1'b1;
    repeat (3) step("R10");
    chk(mst[0] == 3'd1, "R10 setup", int'(mst[0]), 1);
    core[4] = 1'b1;
    #1;
    chk(cpa_bus == core, "R10 cpa_o", int'(cpa_bus), int'(core));
    repeat (4) step("R10");
    chk(mst[0] == 3'd5, "R10 yield", int'(mst[0]), 5);
    idle(3, "R10");

    // random phases: fixed then rotating
    for (int ph = 0; ph < 2; ph++) begin
      rotate   = ph[0];
      limit_en = ph[0];
      limit    = 8'd4;
      for (int k = 0; k < 1500; k++) begin
        for (int n = 0; n < N; n++) begin
          if ($urandom_range(3) == 0)  dma[n]  = ~dma[n];
          if ($urandom_range(15) == 0) core[n] = ~core[n];
          lock[n] = ($urandom_range(19) == 0);
        end
        if ($urandom_range(50) == 0) limit = 8'($urandom_range(6));
        step(ph == 0 ? "R3" : "R7");
      end
      idle(4, "R3");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule